// File: doc/BRIEF.md
# Arcade Input Port and Control Register

This block is a memory-mapped I/O slice for an 8-bit 6502-style bus in a dual-processor arcade board. One bus address is shared by a three-bit control register, which takes writes, and the lower of two input ports, which take reads. The next address up is the second input port. The control register latches three lines:

- a controller strobe;
- a line that both raises an interrupt on the partner processor and decides which processor owns the shared RAM window;
- a bank select for the graphics pattern ROM. In the large-program variant this select also switches a program ROM bank.

The two input ports return one byte each. Each byte combines one serial joystick bit with coin switches, a service button and DIP switch settings.

The player ports are swapped from the usual console arrangement. Player 2 sits at the base address and player 1 at base plus one. Each player has an eight-bit parallel-load shifter. A 1 written to the strobe bit makes both shifters track their buttons live. Writing 0 afterwards freezes a snapshot. Each later read of a player's port returns the next button in a fixed order.

Top module: `arcio_port`

## Requirements
- R1: A bus write to BASE_ADDR latches data bit 0 as the controller strobe; `pad_strobe` shows it from the cycle after the write.
- R2: Data bit 1 of that write drives `peer_irq` from the cycle after the write.
- R3: On the primary instance (IS_PRIMARY=1), `shram_primary` follows data bit 1, and 1 grants the shared RAM window to this processor. On a secondary instance it stays 0.
- R4: A read at BASE_ADDR returns: bit 0 player-2 serial data, bit 1 zero, bit 2 service button, bit 3 `dip_lo[0]`, bit 4 `dip_lo[1]`, bit 5 `coin_sw[0]`, bit 6 `coin_sw[1]`, bit 7 zero. The byte is on `bus_rdata` the cycle after the read strobe.
- R5: A read at BASE_ADDR+1 returns: bit 0 player-1 serial data, bit 1 zero, bits 7..2 `dip_hi[5:0]`. The byte is on `bus_rdata` the cycle after the read strobe.
- R6: Data bit 2 of the control write drives `gfx_bank`, which selects one of two 8 KiB pattern ROM banks.
- R7: With LARGE_PRG=1, `prg_bank` follows data bit 2 as well. Otherwise it is 0.
- R8: Button vectors are ordered bit 0 A, bit 1 B, bit 2 extra 1, bit 3 extra 2, bit 4 Up, bit 5 Down, bit 6 Left, bit 7 Right. After the strobe falls, successive reads of a port return these bits from bit 0 upward, as sampled on the clock edge where the strobe write 0 takes effect.
- R9: After all eight buttons have been read, further reads return serial data 1 until the next strobe.
- R10: While the strobe is 1, every read returns the live A button and does not advance the shifter.
- R11: A read of one port advances only that player's shifter.
- R12: The two coin bits are reported independently; each reflects only its own switch.
- R13: Synchronous reset clears all three control bits and `bus_rdata`, and leaves both shifters returning 1.
- R14: Writes to any address other than BASE_ADDR, and reads at other addresses, change neither the outputs nor `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| p1_btn | input | 8 | Player 1 buttons, R8 order, 1 = pressed |
| p2_btn | input | 8 | Player 2 buttons, R8 order |
| coin_sw | input | 2 | Coin acceptor switches |
| service_sw | input | 1 | Service button |
| dip_lo | input | 2 | DIP switches on the base port |
| dip_hi | input | 6 | DIP switches on the upper port |
| pad_strobe | output | 1 | Controller strobe |
| peer_irq | output | 1 | Interrupt line to partner processor |
| shram_primary | output | 1 | Shared RAM granted to primary |
| gfx_bank | output | 1 | Pattern ROM bank select |
| prg_bank | output | 1 | Program ROM bank select (large-program variant) |

## Verification
Every result arrives exactly one clock after the bus strobe that causes it. The control outputs change on the edge that captures a write. A read byte reaches `bus_rdata` on the edge that samples the read, and the same edge advances that player's shifter. The bench drives inputs shortly after each rising edge. A behavioural model built on bit queues steps on that same edge, and the model is compared with the design at each falling edge, so each comparison falls in the cycle where the result has become due. Directed checks read `bus_rdata` just after the edge that follows each read strobe.

// File: rtl/arcio_pkg.sv
package arcio_pkg;

    localparam int DATA_W   = 8;
    localparam int PAD_BITS = 8;
    localparam int DIP_LO_W = 2;
    localparam int DIP_HI_W = 6;

    // Control bits in write-data order: bank = bit 2, link = bit 1, strobe = bit 0
    typedef struct packed {
        logic bank;
        logic link;
        logic strobe;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_LO   = 2'd1,
        PORT_HI   = 2'd2
    } port_e;

    typedef struct packed {
        logic [1:0]          coin;
        logic                service;
        logic [DIP_LO_W-1:0] dip;
    } lo_misc_t;

    function automatic logic [DATA_W-1:0] pack_lo(input logic ser, input lo_misc_t m);
        return {1'b0, m.coin[1], m.coin[0], m.dip[1], m.dip[0], m.service, 1'b0, ser};
    endfunction

    function automatic logic [DATA_W-1:0] pack_hi(input logic ser,
                                                  input logic [DIP_HI_W-1:0] dip);
        return {dip, 1'b0, ser};
    endfunction

endpackage

// File: rtl/arcio_decode.sv
module arcio_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016
) (
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic                  wr_hit,
    output arcio_pkg::port_e      rd_sel
);
    import arcio_pkg::*;

    localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

    always_comb begin
        wr_hit = bus_wr && (bus_addr == BASE_ADDR);
        rd_sel = PORT_NONE;
        if (bus_rd) begin
            if (bus_addr == BASE_ADDR)    rd_sel = PORT_LO;
            else if (bus_addr == HI_ADDR) rd_sel = PORT_HI;
        end
    end
endmodule

// File: rtl/arcio_ctrl_reg.sv
module arcio_ctrl_reg (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_hit,
    input  logic [arcio_pkg::CTRL_W-1:0]      wr_bits,
    output arcio_pkg::ctrl_t                  ctrl_q
);
    import arcio_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= '0;
        else if (wr_hit) ctrl_q <= ctrl_t'(wr_bits);
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (ctrl_q == ctrl_t'($past(wr_bits)))); // R1
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctrl_q)); // R14
endmodule

// File: rtl/arcio_pad_shift.sv
module arcio_pad_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            adv,
    input  logic [BITS-1:0] btn,
    output logic            ser
);
    logic [BITS-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst)       shift_q <= '1;
        else if (load) shift_q <= btn;
        else if (adv)  shift_q <= {1'b1, shift_q[BITS-1:1]};
    end

    // Live first button while strobing, otherwise the head of the snapshot
    assign ser = load ? btn[0] : shift_q[0];

    AST_SHIFT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (shift_q == $past(btn))); // R10
    AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (rst)
        (!load && adv) |=> shift_q[BITS-1]); // R9
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(shift_q)); // R11
endmodule

// File: rtl/arcio_rd_pack.sv
module arcio_rd_pack (
    input  logic                                clk,
    input  logic                                rst,
    input  arcio_pkg::port_e                    rd_sel,
    input  logic [1:0]                          ser,
    input  arcio_pkg::lo_misc_t                 misc,
    input  logic [arcio_pkg::DIP_HI_W-1:0]      dip_hi,
    output logic [arcio_pkg::DATA_W-1:0]        rdata_q
);
    import arcio_pkg::*;

    // ser[0] belongs to the low port (player 2), ser[1] to the high port (player 1)
    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else begin
            unique case (rd_sel)
                PORT_LO: rdata_q <= pack_lo(ser[0], misc);
                PORT_HI: rdata_q <= pack_hi(ser[1], dip_hi);
                default: rdata_q <= rdata_q;
            endcase
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == PORT_NONE) |=> $stable(rdata_q)); // R14
    AST_RD_SPARE: assert property (@(posedge clk) disable iff (rst)
        (rd_sel != PORT_NONE) |=> (rdata_q[1] == 1'b0)); // R4
    AST_COIN_SEP: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == PORT_LO) |=> (rdata_q[6:5] == $past(misc.coin))); // R12
endmodule

// File: rtl/arcio_port.sv
module arcio_port #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h4016,
    parameter bit                IS_PRIMARY = 1'b1,
    parameter bit                LARGE_PRG  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        p1_btn,
    input  logic [7:0]        p2_btn,
    input  logic [1:0]        coin_sw,
    input  logic              service_sw,
    input  logic [1:0]        dip_lo,
    input  logic [5:0]        dip_hi,
    output logic              pad_strobe,
    output logic              peer_irq,
    output logic              shram_primary,
    output logic              gfx_bank,
    output logic              prg_bank
);
    import arcio_pkg::*;

    localparam int NUM_PADS = 2;

    logic     wr_hit;
    port_e    rd_sel;
    ctrl_t    ctrl_q;
    lo_misc_t misc;
    logic [NUM_PADS-1:0]               ser;
    logic [NUM_PADS-1:0]               adv;
    logic [NUM_PADS-1:0][PAD_BITS-1:0] btn_bus;

    arcio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .wr_hit   (wr_hit),
        .rd_sel   (rd_sel)
    );

    arcio_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .wr_bits (bus_wdata[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q)
    );

    // Index 0: low port, player 2.  Index 1: high port, player 1.
    assign btn_bus[0] = p2_btn;
    assign btn_bus[1] = p1_btn;
    assign adv[0]     = (rd_sel == PORT_LO);
    assign adv[1]     = (rd_sel == PORT_HI);

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        arcio_pad_shift #(.BITS(PAD_BITS)) u_shift (
            .clk  (clk),
            .rst  (rst),
            .load (ctrl_q.strobe),
            .adv  (adv[g]),
            .btn  (btn_bus[g]),
            .ser  (ser[g])
        );
    end

    assign misc.coin    = coin_sw;
    assign misc.service = service_sw;
    assign misc.dip     = dip_lo;

    arcio_rd_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .rd_sel  (rd_sel),
        .ser     (ser),
        .misc    (misc),
        .dip_hi  (dip_hi),
        .rdata_q (bus_rdata)
    );

    assign pad_strobe = ctrl_q.strobe;
    assign peer_irq   = ctrl_q.link;
    assign gfx_bank   = ctrl_q.bank;

    if (IS_PRIMARY) begin : g_primary
        assign shram_primary = ctrl_q.link;
    end else begin : g_secondary
        assign shram_primary = 1'b0;
    end

    if (LARGE_PRG) begin : g_big_prg
        assign prg_bank = ctrl_q.bank;
    end else begin : g_small_prg
        assign prg_bank = 1'b0;
    end

    AST_WR_BIT1: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (peer_irq == $past(bus_wdata[1]))); // R2
    AST_GRANT: assert property (@(posedge clk) disable iff (rst)
        IS_PRIMARY |-> (shram_primary == peer_irq)); // R3
    AST_BANK: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (gfx_bank == $past(bus_wdata[2]))); // R6
    AST_PRG: assert property (@(posedge clk) disable iff (rst)
        LARGE_PRG |-> (prg_bank == gfx_bank)); // R7
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(adv)); // R11
endmodule

// File: tb/tb_arcio_port.sv
module tb_arcio_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h4016;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] p1_btn = '0, p2_btn = '0;
    logic [1:0] coin_sw = '0;
    logic service_sw = 1'b0;
    logic [1:0] dip_lo = '0;
    logic [5:0] dip_hi = '0;
    logic pad_strobe, peer_irq, shram_primary, gfx_bank, prg_bank;

    int n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arcio_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .p1_btn(p1_btn), .p2_btn(p2_btn),
        .coin_sw(coin_sw), .service_sw(service_sw), .dip_lo(dip_lo), .dip_hi(dip_hi),
        .pad_strobe(pad_strobe), .peer_irq(peer_irq), .shram_primary(shram_primary),
        .gfx_bank(gfx_bank), .prg_bank(prg_bank)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_strobe, m_link, m_bank;
    bit q_lo[$];
    bit q_hi[$];
    logic [7:0] m_rd;
    bit m_last_hi;
    bit started;

    function automatic bit head(ref bit q[$]);
        return (q.size() != 0) ? q[0] : 1'b1;
    endfunction

    always @(posedge clk) begin
        bit s_lo, s_hi;
        started = 1'b1;
        if (rst) begin
            m_strobe = 0; m_link = 0; m_bank = 0; m_rd = '0;
            q_lo.delete(); q_hi.delete();
        end else begin
            s_lo = m_strobe ? p2_btn[0] : head(q_lo);
            s_hi = m_strobe ? p1_btn[0] : head(q_hi);
            if (bus_rd && bus_addr == BASE) begin
                m_rd = 8'h00;
                m_rd[0] = s_lo; m_rd[2] = service_sw;
                m_rd[3] = dip_lo[0]; m_rd[4] = dip_lo[1];
                m_rd[5] = coin_sw[0]; m_rd[6] = coin_sw[1];
                m_last_hi = 0;
                if (!m_strobe && q_lo.size() != 0) void'(q_lo.pop_front());
            end else if (bus_rd && bus_addr == BASE + 16'd1) begin
                m_rd = {dip_hi, 1'b0, s_hi};
                m_last_hi = 1;
                if (!m_strobe && q_hi.size() != 0) void'(q_hi.pop_front());
            end
            if (m_strobe) begin
                q_lo.delete(); q_hi.delete();
                for (int i = 0; i < 8; i++) begin
                    q_lo.push_back(p2_btn[i]);
                    q_hi.push_back(p1_btn[i]);
                end
            end
            if (bus_wr && bus_addr == BASE) begin
                m_strobe = bus_wdata[0]; m_link = bus_wdata[1]; m_bank = bus_wdata[2];
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(m_last_hi ? "R5" : "R4", bus_rdata, m_rd);
            chk("R1", {7'd0, pad_strobe}, {7'd0, m_strobe});
            chk("R2", {7'd0, peer_irq}, {7'd0, m_link});
            chk("R3", {7'd0, shram_primary}, {7'd0, m_link});
            chk("R6", {7'd0, gfx_bank}, {7'd0, m_bank});
            chk("R7", {7'd0, prg_bank}, {7'd0, m_bank});
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] snap;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R13 reset state
        chk("R13", bus_rdata, 8'h00);
        chk("R13", {3'd0, pad_strobe, peer_irq, shram_primary, gfx_bank, prg_bank}, 8'h00);
        bus_read(BASE + 16'd1, d);
        chk("R13", {7'd0, d[0]}, 8'h01);

        // R8 serial order, player 1 at high port
        p1_btn = 8'b1011_0010; p2_btn = 8'b0100_1101;
        bus_write(BASE, 8'h01);
        bus_write(BASE, 8'h00);
        snap = 8'b1011_0010;
        p1_btn = 8'h00;   // change after snapshot; must not matter
        for (int i = 0; i < 8; i++) begin
            bus_read(BASE + 16'd1, d);
            chk("R8", {7'd0, d[0]}, {7'd0, snap[i]});
        end
        // R9 exhausted returns 1
        bus_read(BASE + 16'd1, d);
        chk("R9", {7'd0, d[0]}, 8'h01);
        // R11 player 2 untouched by those reads
        bus_read(BASE, d);
        chk("R11", {7'd0, d[0]}, 8'h01);
        bus_read(BASE, d);
        chk("R11", {7'd0, d[0]}, 8'h00);

        // R10 strobe held: live A, no advance
        bus_write(BASE, 8'h01);
        p2_btn = 8'h01;
        bus_read(BASE, d);
        chk("R10", {7'd0, d[0]}, 8'h01);
        p2_btn = 8'hFE;
        bus_read(BASE, d);
        chk("R10", {7'd0, d[0]}, 8'h00);
        bus_read(BASE, d);
        chk("R10", {7'd0, d[0]}, 8'h00);

        // R12 coin independence, R4 layout
        bus_write(BASE, 8'h00);
        coin_sw = 2'b01; service_sw = 1'b1; dip_lo = 2'b10;
        bus_read(BASE, d);
        chk("R12", {6'd0, d[6:5]}, 8'h01);
        chk("R4", d & 8'hFE, 8'b0011_0100);
        coin_sw = 2'b10; service_sw = 1'b0; dip_lo = 2'b01;
        bus_read(BASE, d);
        chk("R12", {6'd0, d[6:5]}, 8'h02);
        chk("R4", d & 8'hFE, 8'b0100_1000);
        coin_sw = 2'b11;
        bus_read(BASE, d);
        chk("R12", {6'd0, d[6:5]}, 8'h03);

        // R5 layout
        dip_hi = 6'b101101;
        bus_read(BASE + 16'd1, d);
        chk("R5", d & 8'hFE, 8'b1011_0100);

        // R2 R3 R6 R7 control bits
        bus_write(BASE, 8'hFE);
        chk("R2", {7'd0, peer_irq}, 8'h01);
        chk("R3", {7'd0, shram_primary}, 8'h01);
        chk("R6", {7'd0, gfx_bank}, 8'h01);
        chk("R7", {7'd0, prg_bank}, 8'h01);
        chk("R1", {7'd0, pad_strobe}, 8'h00);

        // R14 other addresses ignored
        bus_write(BASE + 16'd1, 8'h00);
        bus_write(16'h4020, 8'h01);
        chk("R14", {5'd0, gfx_bank, peer_irq, pad_strobe}, 8'h06);
        d = bus_rdata;
        bus_read(16'h4018, snap);
        chk("R14", bus_rdata, d);

        bus_write(BASE, 8'h04);
        chk("R2", {7'd0, peer_irq}, 8'h00);
        chk("R6", {7'd0, gfx_bank}, 8'h01);

        // R13 reset mid-run
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        chk("R13", {3'd0, pad_strobe, peer_irq, shram_primary, gfx_bank, prg_bank}, 8'h00);
        chk("R13", bus_rdata, 8'h00);
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end
endmodule